// File: doc/BRIEF.md
# UART Interrupt Priority Controller

This block merges the interrupt sources of a 16550-style serial port into a single interrupt request and an eight-bit identification byte. It holds the four-bit interrupt enable register, the sticky overrun and break flags, and the one-shot "transmit holding empty" pending latch. From these, and from level inputs supplied by the receive and transmit engines, it picks the most urgent enabled source every cycle. The serial engines, the FIFOs and the register decoder sit outside. They drive plain level inputs and one-cycle strobes: an enable write, an ID read, a line status read, a transmit byte write and a transmit FIFO clear.

No data moves through this block, so it has no valid/ready interface. Every pin is a plain control or status signal. A strobe acts in the cycle in which it is high, and it has no back-pressure.

The identification byte and the interrupt request are registered. Both reflect a source change, or a strobe, on the clock edge that follows it. The bus side reads the ID from `irq_id`. It pulses `id_rd` in the cycle in which it samples that value.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The low nibble of `irq_id` gives the highest-priority enabled source. The codes, from highest priority to lowest, are:
  - 0x6: line status error. This is the overrun, parity, framing or break flag, gated by enable bit 2.
  - 0xC: character timeout.
  - 0x4: receive data available.
  - 0x2: transmit holding empty, gated by enable bit 1.
  - 0x0: modem status change. This is any `msr_delta` bit, gated by enable bit 3.
  - 0x1: nothing pending.
- R2: `irq_id[7:6]` reads 2'b11 while `fifo_en` is high and 2'b00 otherwise. `irq_id[5:4]` is always 0.
- R3: The character timeout source is enabled only by enable bit 0. Enable bits 1 to 3 have no effect on it.
- R4: Receive data is gated by enable bit 0. With `fifo_en` high, it is reported only while `data_ready` is high and `rx_count >= rx_trig`. With `fifo_en` low, it follows `data_ready` alone.
- R5: An `id_rd` strobe in a cycle where `irq_id[3:0]` is 0x2 clears the transmit-empty pending latch. An `id_rd` strobe while another code is shown leaves the latch as it is.
- R6: An enable write that sets bit 1, when it was 0 before, sets the pending latch if `thr_empty` is high. An enable write that clears bit 1, when it was 1 before, clears the latch.
- R7: The `tx_write` strobe clears the pending latch. The `tx_fifo_clr` strobe sets it. A rising edge on `thr_empty` also sets it. When several of these occur in one cycle, the FIFO clear wins, then the rising edge, then the byte write.
- R8: An enable write stores only `ier_wdata[3:0]`, and `ier_q` shows the stored value.
- R9: `line_err` shows {break, framing, parity, overrun} in bits 3 to 0. Overrun and break are sticky. An `lsr_rd` strobe clears them, but a set strobe in the same cycle wins. Parity and framing follow their inputs.
- R10: `irq` is a registered output. It is high exactly when `irq_id[3:0]` is not 0x1, and it changes on the same edge as `irq_id`.
- R11: After reset, `ier_q` is 0, the pending latch is 0, `irq_id` is 0x01 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Strobe that writes the enable register |
| ier_wdata | input | 8 | Write data for the enable register; only bits 3:0 are kept |
| ier_q | output | 4 | Enable register contents |
| fifo_en | input | 1 | FIFO mode is active |
| oe_set | input | 1 | Strobe: overrun detected |
| bi_set | input | 1 | Strobe: break detected |
| pe_err | input | 1 | Parity error level from the receive path |
| fe_err | input | 1 | Framing error level from the receive path |
| lsr_rd | input | 1 | Strobe: line status register read |
| line_err | output | 4 | {break, framing, parity, overrun} |
| data_ready | input | 1 | Receive data ready |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| timeout_pend | input | 1 | Character timeout pending |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_write | input | 1 | Strobe: transmit byte written |
| tx_fifo_clr | input | 1 | Strobe: transmit FIFO cleared |
| msr_delta | input | 4 | Modem status delta bits |
| id_rd | input | 1 | Strobe: identification register read |
| irq_id | output | 8 | Registered identification byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets two kinds of corner case: the one-shot transmit latch and the masking corners.

For the transmit latch, it checks four things:
- A design that cleared the latch on any ID read would lose a pending transmit-empty interrupt that a receive-data code was hiding.
- A design without the re-arm rule would stay silent after the enable bit is toggled.
- A design that set the latch when the holding register was not empty would raise a false 0x2.
- A design that ignored the rising edge of `thr_empty` would miss the interrupt when the transmitter drains.

For the masking corners, it checks four more:
- A timeout that is not masked by enable bit 0 would show 0xC with only line status enabled.
- A receive FIFO one entry below its trigger would wrongly show 0x4.
- Overrun or break flags that survive a status read would hold `irq` high for good.
- Modem code 0x00 must still raise `irq`.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    IRQ_MODEM   = 4'h0,
    IRQ_NONE    = 4'h1,
    IRQ_THRE    = 4'h2,
    IRQ_RXDATA  = 4'h4,
    IRQ_LINE    = 4'h6,
    IRQ_TIMEOUT = 4'hC
  } irq_code_e;

  // source index 0 is the most urgent
  localparam int NSRC = 5;
  typedef logic [NSRC-1:0] src_vec_t;

  function automatic irq_code_e src_code(input int idx);
    case (idx)
      0:       return IRQ_LINE;
      1:       return IRQ_TIMEOUT;
      2:       return IRQ_RXDATA;
      3:       return IRQ_THRE;
      default: return IRQ_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_linestat.sv
module uart_irq_linestat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oe_set,
  input  logic       bi_set,
  input  logic       pe_err,
  input  logic       fe_err,
  input  logic       lsr_rd,
  output logic [3:0] err_d,
  output logic [3:0] err_q
);
  logic oe_q, bi_q, pe_q, fe_q;
  logic oe_d, bi_d;

  // a new event wins over a clearing read in the same cycle
  always_comb begin
    oe_d = oe_set ? 1'b1 : (lsr_rd ? 1'b0 : oe_q);
    bi_d = bi_set ? 1'b1 : (lsr_rd ? 1'b0 : bi_q);
  end

  assign err_d = {bi_d, fe_err, pe_err, oe_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      bi_q <= 1'b0;
      pe_q <= 1'b0;
      fe_q <= 1'b0;
    end else begin
      oe_q <= oe_d;
      bi_q <= bi_d;
      pe_q <= pe_err;
      fe_q <= fe_err;
    end
  end

  assign err_q = {bi_q, fe_q, pe_q, oe_q};
endmodule

// File: rtl/uart_irq_thre_latch.sv
module uart_irq_thre_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ier_wr,
  input  logic en_old,
  input  logic en_new,
  input  logic thr_empty,
  input  logic tx_write,
  input  logic tx_fifo_clr,
  input  logic id_rd,
  input  logic id_is_thre,
  output logic pend_d
);
  logic pend_q;
  logic empty_q;
  logic empty_rise;

  assign empty_rise = thr_empty & ~empty_q;

  // later assignments take precedence
  always_comb begin
    pend_d = pend_q;
    if (ier_wr && (en_old != en_new))
      pend_d = en_new & thr_empty;
    if (id_rd && id_is_thre)
      pend_d = 1'b0;
    if (tx_write)
      pend_d = 1'b0;
    if (empty_rise)
      pend_d = 1'b1;
    if (tx_fifo_clr)
      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      pend_q  <= pend_d;
      empty_q <= thr_empty;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  src_vec_t  active,
  output irq_code_e code
);
  // walk from least to most urgent so the most urgent match overwrites
  always_comb begin
    code = IRQ_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) code = src_code(i);
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  output logic [3:0]       ier_q,
  input  logic             fifo_en,
  input  logic             oe_set,
  input  logic             bi_set,
  input  logic             pe_err,
  input  logic             fe_err,
  input  logic             lsr_rd,
  output logic [3:0]       line_err,
  input  logic             data_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             timeout_pend,
  input  logic             thr_empty,
  input  logic             tx_write,
  input  logic             tx_fifo_clr,
  input  logic [3:0]       msr_delta,
  input  logic             id_rd,
  output logic [7:0]       irq_id,
  output logic             irq
);
  localparam logic [7:0] ID_RESET = {4'h0, IRQ_NONE};

  logic [3:0] ier_d;
  logic [3:0] err_d;
  logic       thre_pend_d;
  logic       rx_level_ok;
  src_vec_t   active;
  irq_code_e  code;
  logic [7:0] id_q;
  logic       irq_q;

  assign ier_d = ier_wr ? ier_wdata[3:0] : ier_q;

  uart_irq_linestat u_ls (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe_set (oe_set),
    .bi_set (bi_set),
    .pe_err (pe_err),
    .fe_err (fe_err),
    .lsr_rd (lsr_rd),
    .err_d  (err_d),
    .err_q  (line_err)
  );

  uart_irq_thre_latch u_thre (
    .clk         (clk),
    .rst_n       (rst_n),
    .ier_wr      (ier_wr),
    .en_old      (ier_q[1]),
    .en_new      (ier_wdata[1]),
    .thr_empty   (thr_empty),
    .tx_write    (tx_write),
    .tx_fifo_clr (tx_fifo_clr),
    .id_rd       (id_rd),
    .id_is_thre  (id_q[3:0] == IRQ_THRE),
    .pend_d      (thre_pend_d)
  );

  assign rx_level_ok = ~fifo_en | (rx_count >= rx_trig);

  always_comb begin
    active[0] = ier_d[2] & (|err_d);
    active[1] = ier_d[0] & timeout_pend;
    active[2] = ier_d[0] & data_ready & rx_level_ok;
    active[3] = ier_d[1] & thre_pend_d;
    active[4] = ier_d[3] & (|msr_delta);
  end

  uart_irq_prio u_prio (
    .active (active),
    .code   (code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= 4'h0;
      id_q  <= ID_RESET;
      irq_q <= 1'b0;
    end else begin
      ier_q <= ier_d;
      id_q  <= {fifo_en, fifo_en, 2'b00, code};
      irq_q <= (code != IRQ_NONE);
    end
  end

  assign irq_id = id_q;
  assign irq    = irq_q;
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ier_wr,
  input logic [7:0]       ier_wdata,
  input logic [3:0]       ier_q,
  input logic             fifo_en,
  input logic             oe_set,
  input logic             bi_set,
  input logic             lsr_rd,
  input logic [3:0]       line_err,
  input logic             data_ready,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] rx_trig,
  input logic             thr_empty,
  input logic             tx_fifo_clr,
  input logic             id_rd,
  input logic [7:0]       irq_id,
  input logic             irq
);
  // R8
  ier_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier_q == $past(ier_wdata[3:0]));

  // R5
  thre_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && irq_id[3:0] == 4'h2 && !tx_fifo_clr && !ier_wr && $stable(thr_empty))
    |=> irq_id[3:0] != 4'h2);

  // R9
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !oe_set && !bi_set) |=> (line_err[0] == 1'b0 && line_err[3] == 1'b0));

  // R3
  timeout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id[3:0] == 4'hC) |-> ier_q[0]);

  // R2
  fifo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_id[7:4] == {$past(fifo_en), $past(fifo_en), 2'b00}));

  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq == (irq_id[3:0] != 4'h1)));

  // R4
  rx_below_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (rx_count < rx_trig)) |=> irq_id[3:0] != 4'h4);

  // R4
  rx_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |=> irq_id[3:0] != 4'h4);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ier_wr      (ier_wr),
  .ier_wdata   (ier_wdata),
  .ier_q       (ier_q),
  .fifo_en     (fifo_en),
  .oe_set      (oe_set),
  .bi_set      (bi_set),
  .lsr_rd      (lsr_rd),
  .line_err    (line_err),
  .data_ready  (data_ready),
  .rx_count    (rx_count),
  .rx_trig     (rx_trig),
  .thr_empty   (thr_empty),
  .tx_fifo_clr (tx_fifo_clr),
  .id_rd       (id_rd),
  .irq_id      (irq_id),
  .irq         (irq)
);

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 1'b0;
  logic [7:0] ier_wdata = 8'h00;
  logic [3:0] ier_q;
  logic fifo_en = 1'b0;
  logic oe_set = 1'b0, bi_set = 1'b0, pe_err = 1'b0, fe_err = 1'b0, lsr_rd = 1'b0;
  logic [3:0] line_err;
  logic data_ready = 1'b0;
  logic [CNT_W-1:0] rx_count = '0, rx_trig = '0;
  logic timeout_pend = 1'b0;
  logic thr_empty = 1'b1;
  logic tx_write = 1'b0, tx_fifo_clr = 1'b0;
  logic [3:0] msr_delta = 4'h0;
  logic id_rd = 1'b0;
  logic [7:0] irq_id;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_q(ier_q),
    .fifo_en(fifo_en), .oe_set(oe_set), .bi_set(bi_set), .pe_err(pe_err),
    .fe_err(fe_err), .lsr_rd(lsr_rd), .line_err(line_err), .data_ready(data_ready),
    .rx_count(rx_count), .rx_trig(rx_trig), .timeout_pend(timeout_pend),
    .thr_empty(thr_empty), .tx_write(tx_write), .tx_fifo_clr(tx_fifo_clr),
    .msr_delta(msr_delta), .id_rd(id_rd), .irq_id(irq_id), .irq(irq)
  );

  // fields: [31:28] enable, [27] fifo, [26] parity, [25] framing, [24] data ready,
  // [23:19] count, [18:14] trigger, [13] timeout, [12:9] modem delta, [7:0] expected id
  localparam int NVEC = 12;
  localparam logic [31:0] VEC [NVEC] = '{
    {4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd0, 5'd0, 1'b1, 4'h1, 1'b0, 8'h01},
    {4'hD, 1'b1, 1'b1, 1'b0, 1'b1, 5'd0, 5'd0, 1'b1, 4'h1, 1'b0, 8'hC6},
    {4'hD, 1'b1, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 1'b1, 4'h1, 1'b0, 8'hCC},
    {4'h8, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 1'b1, 4'h1, 1'b0, 8'h00},
    {4'h1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd3, 5'd4, 1'b0, 4'h0, 1'b0, 8'hC1},
    {4'h1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd4, 5'd4, 1'b0, 4'h0, 1'b0, 8'hC4},
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd4, 1'b0, 4'h0, 1'b0, 8'h04},
    {4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 5'd4, 1'b1, 4'h0, 1'b0, 8'hCC},
    {4'h4, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 5'd4, 1'b1, 4'h0, 1'b0, 8'hC1},
    {4'h4, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0, 5'd4, 1'b1, 4'h0, 1'b0, 8'hC6},
    {4'h8, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd4, 1'b0, 4'h4, 1'b0, 8'h00},
    {4'h9, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd4, 1'b0, 4'h1, 1'b0, 8'h04}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // strobe for one cycle; outputs are checked at the following negedge
  task automatic write_ier(input logic [7:0] v);
    @(negedge clk); ier_wr = 1'b1; ier_wdata = v;
    @(negedge clk); ier_wr = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic check_id(input string req, input logic [7:0] exp);
    check(req, irq_id, exp);
    check({req, " irq"}, {7'd0, irq}, {7'd0, exp[3:0] != 4'h1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 id", irq_id, 8'h01);
    check("R11 irq", {7'd0, irq}, 8'h00);
    check("R11 ier", {4'h0, ier_q}, 8'h00);
    rst_n = 1'b1;
    settle();
    check("R11 id after release", irq_id, 8'h01);

    // R1 R2 R3 R4 R10 table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      fifo_en = VEC[i][27]; pe_err = VEC[i][26]; fe_err = VEC[i][25];
      data_ready = VEC[i][24]; rx_count = VEC[i][23:19]; rx_trig = VEC[i][18:14];
      timeout_pend = VEC[i][13]; msr_delta = VEC[i][12:9];
      ier_wr = 1'b1; ier_wdata = {4'h0, VEC[i][31:28]};
      @(negedge clk); ier_wr = 1'b0;
      check_id($sformatf("R1/R2/R3/R4 vec%0d", i), VEC[i][7:0]);
    end

    @(negedge clk);
    fifo_en = 1'b0; pe_err = 1'b0; fe_err = 1'b0; data_ready = 1'b0;
    timeout_pend = 1'b0; msr_delta = 4'h0;
    write_ier(8'h00);
    check_id("R1 idle", 8'h01);

    // R8 upper bits dropped; R6 rearm on enable with empty holding register
    write_ier(8'hFF);
    check("R8 ier", {4'h0, ier_q}, 8'h0F);
    check_id("R6 set on enable", 8'h02);
    // R5 read while showing 0x2 clears
    @(negedge clk); id_rd = 1'b1; @(negedge clk); id_rd = 1'b0;
    check_id("R5 read clears", 8'h01);
    // R6 rearm after toggle
    write_ier(8'h00);
    write_ier(8'h02);
    check_id("R6 rearm", 8'h02);
    // R7 byte write clears
    @(negedge clk); tx_write = 1'b1; thr_empty = 1'b0; @(negedge clk); tx_write = 1'b0;
    check_id("R7 tx write", 8'h01);
    // R7 rising empty sets
    @(negedge clk); thr_empty = 1'b1; settle();
    check_id("R7 empty rise", 8'h02);
    @(negedge clk); id_rd = 1'b1; @(negedge clk); id_rd = 1'b0;
    check_id("R5 cleared again", 8'h01);
    // R7 fifo clear sets
    @(negedge clk); tx_fifo_clr = 1'b1; @(negedge clk); tx_fifo_clr = 1'b0;
    check_id("R7 fifo clear", 8'h02);
    // R6 disable clears, enable with busy holding register does not set
    write_ier(8'h00);
    check_id("R6 disable", 8'h01);
    @(negedge clk); thr_empty = 1'b0;
    write_ier(8'h02);
    check_id("R6 not empty", 8'h01);
    @(negedge clk); thr_empty = 1'b1; settle();
    check_id("R7 rise after enable", 8'h02);
    // R5 read while 0x4 shown keeps latch
    write_ier(8'h03);
    @(negedge clk); data_ready = 1'b1; settle();
    check_id("R1 rx over thre", 8'h04);
    @(negedge clk); id_rd = 1'b1; @(negedge clk); id_rd = 1'b0;
    check_id("R5 other read", 8'h04);
    @(negedge clk); data_ready = 1'b0; settle();
    check_id("R5 latch kept", 8'h02);

    // R9 line status sticky flags
    write_ier(8'h04);
    @(negedge clk); oe_set = 1'b1; @(negedge clk); oe_set = 1'b0;
    check_id("R9 overrun", 8'h06);
    check("R9 line_err oe", {4'h0, line_err}, 8'h01);
    @(negedge clk); lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    check_id("R9 read clears", 8'h01);
    check("R9 line_err clr", {4'h0, line_err}, 8'h00);
    @(negedge clk); bi_set = 1'b1; @(negedge clk); bi_set = 1'b0;
    check("R9 line_err bi", {4'h0, line_err}, 8'h08);
    @(negedge clk); pe_err = 1'b1; lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    check("R9 parity stays", {4'h0, line_err}, 8'h02);
    check_id("R9 parity id", 8'h06);
    @(negedge clk); oe_set = 1'b1; lsr_rd = 1'b1; @(negedge clk); oe_set = 1'b0; lsr_rd = 1'b0;
    check("R9 set wins", {4'h0, line_err}, 8'h03);
    @(negedge clk); pe_err = 1'b0; lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    check_id("R9 all clear", 8'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule